// File: doc/BRIEF.md
# Single-Dot LED Matrix Scanner

This block lights a 16x16 LED matrix one dot at a time. A 256-bit frame vector holds one bit per LED. An internal scan position steps through every LED location, one location per clock cycle. When the frame bit at the current location is set, the block drives that LED's row and column lines to their active levels. At a 50 MHz system clock the full image is swept about 195,000 times per second, so persistence of vision makes the matrix look continuously lit. The matrix can be built from four 8x8 panels wired as one 16x16 array.

Column lines are active high and row lines are active low. A dot lights only when its column is high and its row is low. Every line that is not selected stays at its inactive level: rows high, columns low. The frame vector can change at any time. The value present at a clock edge is the one used for the location latched at that edge.

Top module: `led_dot_scanner`

## Requirements
- R1: While reset is high at a clock edge, all row lines go high, all column lines go low, and the scan position returns to 0. The first edge after reset drives position 0.
- R2: The scan position advances by exactly one per clock cycle and wraps from 255 to 0.
- R3: Position bits [7:4] select the row line and bits [3:0] select the column line. The LED at row r and column c uses frame bit r*16+c.
- R4: When the selected frame bit is 1, the outputs drive exactly that row low and that column high.
- R5: When the selected frame bit is 0, all rows are high and all columns are low, so nothing is lit.
- R6: The number of low rows is at most one and equals the number of high columns.
- R7: The outputs are registered. The pins seen after the k-th clock edge since reset release show position k-1, using the frame value present at that edge.
- R8: Each of the 256 positions is visited once per 256 cycles, so a fully set frame lights every LED once in each sweep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one LED location per cycle |
| rst | input | 1 | Synchronous active-high reset |
| frame | input | 256 | Image, one bit per LED, bit r*16+c for row r, column c |
| row_n | output | 16 | Row lines, active low |
| col | output | 16 | Column lines, active high |

## Verification
The assertions take for granted that reset is applied at the first clock edge. This gives the scan counter and pins a known value before any step or lit-dot property is evaluated. They also take for granted that `frame` is stable across each sampling edge, because a lit dot is tied to the frame bit seen at that edge. The stimulus asserts reset before the first edge and changes `frame` only on falling edges. It walks constant patterns over full sweeps and makes one mid-sweep frame change. It also asserts reset mid-sweep, so every position is sampled with both bit values.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

    localparam int unsigned N_ROWS = 16;
    localparam int unsigned N_COLS = 16;
    localparam int unsigned N_DOTS = N_ROWS * N_COLS;
    localparam int unsigned ROW_W  = $clog2(N_ROWS);
    localparam int unsigned COL_W  = $clog2(N_COLS);
    localparam int unsigned POS_W  = ROW_W + COL_W;

    typedef logic [ROW_W-1:0] row_idx_t;
    typedef logic [COL_W-1:0] col_idx_t;

    // Row index in the upper bits, so {row,col} equals row*N_COLS+col.
    typedef struct packed {
        row_idx_t row;
        col_idx_t col;
    } scan_pos_t;

    typedef struct packed {
        logic [N_ROWS-1:0] row_n;
        logic [N_COLS-1:0] col_hi;
    } pin_vec_t;

    function automatic pin_vec_t pins_idle();
        pin_vec_t p;
        p.row_n  = '1;
        p.col_hi = '0;
        return p;
    endfunction

    function automatic pin_vec_t pins_for(scan_pos_t pos, logic on);
        pin_vec_t p;
        p = pins_idle();
        if (on) begin
            p.row_n[pos.row]  = 1'b0;
            p.col_hi[pos.col] = 1'b1;
        end
        return p;
    endfunction

endpackage

// File: rtl/scan_counter.sv
module scan_counter
    import led_scan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    output scan_pos_t pos
);
    logic [POS_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + POS_W'(1);
    end

    assign pos = scan_pos_t'(cnt);

    property p_step;
        @(posedge clk) disable iff (rst) 1'b1 |=> (cnt == $past(cnt) + POS_W'(1));
    endproperty
    assert_scan_step_R2: assert property (p_step);

    property p_reset_pos;
        @(posedge clk) rst |=> (cnt == '0);
    endproperty
    assert_reset_pos_R1: assert property (p_reset_pos);
endmodule

// File: rtl/dot_select.sv
module dot_select
    import led_scan_pkg::*;
(
    input  logic [N_DOTS-1:0] frame,
    input  scan_pos_t         pos,
    output logic              dot_on
);
    // The packed position is the frame bit index (R3).
    always_comb dot_on = frame[POS_W'(pos)];
endmodule

// File: rtl/pin_driver.sv
module pin_driver
    import led_scan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  scan_pos_t pos,
    input  logic      dot_on,
    output pin_vec_t  pins
);
    always_ff @(posedge clk) begin
        if (rst) pins <= pins_idle();
        else     pins <= pins_for(pos, dot_on);
    end

    property p_reset_pins;
        @(posedge clk) rst |=> (pins.row_n == '1 && pins.col_hi == '0);
    endproperty
    assert_reset_pins_R1: assert property (p_reset_pins);

    property p_lit;
        @(posedge clk) disable iff (rst)
            dot_on |=> (!pins.row_n[$past(pos.row)] && pins.col_hi[$past(pos.col)]);
    endproperty
    assert_dot_lit_R4: assert property (p_lit);

    property p_blank;
        @(posedge clk) disable iff (rst)
            !dot_on |=> (pins.row_n == '1 && pins.col_hi == '0);
    endproperty
    assert_dot_blank_R5: assert property (p_blank);

    property p_single;
        @(posedge clk) disable iff (rst)
            $onehot0(~pins.row_n) && $onehot0(pins.col_hi) &&
            ($countones(~pins.row_n) == $countones(pins.col_hi));
    endproperty
    assert_single_dot_R6: assert property (p_single);
endmodule

// File: rtl/led_dot_scanner.sv
module led_dot_scanner
    import led_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_DOTS-1:0] frame,
    output logic [N_ROWS-1:0] row_n,
    output logic [N_COLS-1:0] col
);
    scan_pos_t pos;
    logic      dot_on;
    pin_vec_t  pins;

    scan_counter u_cnt (
        .clk (clk),
        .rst (rst),
        .pos (pos)
    );

    dot_select u_sel (
        .frame  (frame),
        .pos    (pos),
        .dot_on (dot_on)
    );

    pin_driver u_drv (
        .clk    (clk),
        .rst    (rst),
        .pos    (pos),
        .dot_on (dot_on),
        .pins   (pins)
    );

    assign row_n = pins.row_n;
    assign col   = pins.col_hi;
endmodule

// File: tb/sim_led_dot_scanner.sv
module sim_led_dot_scanner;
    localparam time CLK_PERIOD = 20ns;
    localparam int  NPAT = 6;
    localparam logic [255:0] PATS [NPAT] = '{
        {256{1'b1}},
        {256{1'b0}},
        {64{4'h5}},
        {16{16'h8001}},
        {8{32'h0000FFFF}},
        {32{8'hC3}}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [255:0] frame = '0;
    logic [15:0]  row_n, col;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_pos = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    led_dot_scanner u0 (
        .clk   (clk),
        .rst   (rst),
        .frame (frame),
        .row_n (row_n),
        .col   (col)
    );

    task automatic check(input string req, input logic [15:0] ar, ac, er, ec);
        n_tests++;
        if (ar !== er || ac !== ec) begin
            n_fail++;
            $display("FAIL %s: row_n=%h col=%h expected row_n=%h col=%h",
                     req, ar, ac, er, ec);
        end
    endtask

    // One clock; the outputs must show exp_pos with the frame held since the last falling edge.
    task automatic step();
        int r, c;
        logic on;
        logic [15:0] er, ec;
        r  = exp_pos / 16;
        c  = exp_pos % 16;
        on = frame[exp_pos];
        @(posedge clk);
        @(negedge clk);
        er = on ? ~(16'h1 << r) : 16'hFFFF;
        ec = on ?  (16'h1 << c) : 16'h0000;
        check(on ? "R4/R3/R7" : "R5/R7", row_n, col, er, ec);
        n_tests++;
        if (!($countones(~row_n) <= 1 && $countones(~row_n) == $countones(col))) begin
            n_fail++;
            $display("FAIL R6: row_n=%h col=%h expected at most one matched line pair", row_n, col);
        end
        exp_pos = (exp_pos + 1) % 256;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset pins", row_n, col, 16'hFFFF, 16'h0000);
        rst = 1'b0;
        exp_pos = 0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // Table walk: each pattern over a full sweep (R2, R8).
        for (int p = 0; p < NPAT; p++) begin
            frame = PATS[p];
            for (int i = 0; i < 256; i++) step();
        end
        // Wrap: after full sweeps the scan is back at position 0 (R2, R8).
        frame = '1;
        check("R8 wrap position", 16'(exp_pos), 16'h0, 16'h0, 16'h0);
        step();
        check("R2 wrap to row0 col0", row_n, col, 16'hFFFE, 16'h0001);
        // Mid-sweep frame change is used from the next edge on (R7).
        for (int i = 0; i < 40; i++) step();
        frame = '0;
        step();
        check("R7 frame change blanks", row_n, col, 16'hFFFF, 16'h0000);
        frame = '0;
        frame[exp_pos] = 1'b1;
        step();
        // Last corner: position 255 (row 15, col 15) (R3).
        frame = '0;
        frame[255] = 1'b1;
        while (exp_pos != 255) step();
        step();
        check("R3 corner row15 col15", row_n, col, 16'h7FFF, 16'h8000);
        // Reset in the middle of a sweep restarts at position 0 (R1).
        frame = '1;
        for (int i = 0; i < 77; i++) step();
        do_reset();
        step();
        check("R1 restart at position 0", row_n, col, 16'hFFFE, 16'h0001);
        for (int i = 0; i < 20; i++) step();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule